// File: doc/BRIEF.md
# Priority-Arbitrated Supervisor Return Unit

This unit performs one supervisor return. When it is started, it weighs the priority of the thread that was interrupted against every pending request. Pending requests include external interrupts, deferred software interrupts, timer ticks and inter-processor interrupts, and all of them are treated alike. If a pending request outranks the thread, control goes straight back to the dispatcher. Otherwise the unit asks memory for the thread's saved state, which is five consecutive cache lines, and forwards each returned line into the register file. When the last line has landed and one final check finds nothing of higher rank, it signals that the thread may resume.

The unit keeps watching the request vector for the whole time the lines are in flight. If a request that outranks the thread shows up, the restore is abandoned. Lines that have already arrived are thrown away, the lines still due are swallowed as they arrive, and the dispatcher is entered with the register bank that is already in use. The register bank is chosen by the privilege level being entered, and a bank swap is flagged only when that level differs from the current one.

Top module: `sup_return_arb`

## Requirements
- R1: The chosen request is the valid request with the largest priority. On a tie, the lowest index wins. A request whose priority merely equals the thread's priority never displaces the thread.
- R2: If a valid request outranks the thread priority when `start` is sampled, `redirect` pulses on the next cycle with the winner on `tgt_idx`/`tgt_priv`, and no fetch is issued.
- R3: If nothing outranks the thread at start, `fetch_req` pulses for one cycle after the start edge and `busy` stays high until the return finishes.
- R4: While fetching, each `rsp_valid` is passed through the same cycle as `rf_wr_en` with `rf_wr_data` and `rf_wr_line` counting 0,1,2,3,4 in order.
- R5: The cycle after the fifth line is accepted is a final check. If no request outranks the thread then, `done` pulses one cycle later with `tgt_thread` high and `resume_kind` equal to the latched 4-bit frame kind (1 interrupt, 2 exception, 3 supervisor call).
- R6: A request outranking the thread during the fetch suppresses `rf_wr_en` in that cycle. `redirect` pulses on the next cycle and no `done` follows. Every line response still due, including one that arrives in the abandon cycle, is ignored until five responses have been seen.
- R7: A request outranking the thread in the final-check cycle produces `redirect` instead of `done`.
- R8: On `redirect`, `rf_bank` equals `cur_priv` and `bank_swap` is 0. On `done`, `rf_bank` and `tgt_priv` equal the latched 2-bit frame privilege, and `bank_swap` is 1 exactly when that differs from `cur_priv`.
- R9: `start` is ignored while `busy` is high, including while leftover responses are drained.
- R10: After reset, `busy`, `done`, `redirect`, `fetch_req` and `rf_wr_en` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a supervisor return |
| thread_prio | input | PRIO_W | Priority of the interrupted thread |
| frame_priv | input | 2 | Interrupted privilege level from the stack frame |
| frame_kind | input | 4 | Frame kind code from the stack frame |
| cur_priv | input | 2 | Privilege level whose register bank is in use |
| req_valid | input | NREQ | Pending request flags |
| req_prio | input | NREQ*PRIO_W | Packed request priorities, request i at bits i*PRIO_W |
| req_priv | input | NREQ*2 | Packed request privilege levels |
| rsp_valid | input | 1 | Memory returns one state line |
| rsp_data | input | DATA_W | Returned line data |
| busy | output | 1 | A return is in progress |
| fetch_req | output | 1 | Pulse requesting the saved-state lines |
| rf_wr_en | output | 1 | Write of a restored line into the register file |
| rf_wr_line | output | CW | Line index of the write |
| rf_wr_data | output | DATA_W | Line data of the write |
| done | output | 1 | Pulse: resume the interrupted thread |
| redirect | output | 1 | Pulse: enter the dispatcher for a request |
| tgt_thread | output | 1 | Last target was the interrupted thread |
| tgt_idx | output | IW | Index of the winning request |
| tgt_priv | output | 2 | Privilege level of the target |
| rf_bank | output | 2 | Register-file bank to use |
| bank_swap | output | 1 | Bank differs from the current one |
| resume_kind | output | 4 | Frame kind delivered with done |

## Verification
The bench sweeps every valid mask against several priority sets and every thread priority. That sweep catches an arbiter that breaks ties toward the high index, or that lets an equal priority displace the thread, because either fault sends the return to the wrong target or starts a fetch when it should not. It abandons the fetch at each line position, both with and without a response arriving in the abandon cycle. A counter that counts that response wrongly leaves the unit hung busy or frees it too early. A unit that accepts a start while draining emits a stray fetch. The bench also raises a request in the final-check cycle, which exposes a design that signals done without looking one last time, and it checks that bank swap follows the privilege comparison in both directions.

// File: rtl/sup_return_arb.sv
module sup_return_arb #(
  parameter int NREQ   = 4,
  parameter int PRIO_W = 3,
  parameter int DATA_W = 16,
  parameter int LINES  = 5,
  localparam int IW = (NREQ > 1) ? $clog2(NREQ) : 1,
  localparam int CW = $clog2(LINES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [PRIO_W-1:0]    thread_prio,
  input  logic [1:0]           frame_priv,
  input  logic [3:0]           frame_kind,
  input  logic [1:0]           cur_priv,
  input  logic [NREQ-1:0]      req_valid,
  input  logic [NREQ*PRIO_W-1:0] req_prio,
  input  logic [NREQ*2-1:0]    req_priv,
  input  logic                 rsp_valid,
  input  logic [DATA_W-1:0]    rsp_data,
  output logic                 busy,
  output logic                 fetch_req,
  output logic                 rf_wr_en,
  output logic [CW-1:0]        rf_wr_line,
  output logic [DATA_W-1:0]    rf_wr_data,
  output logic                 done,
  output logic                 redirect,
  output logic                 tgt_thread,
  output logic [IW-1:0]        tgt_idx,
  output logic [1:0]           tgt_priv,
  output logic [1:0]           rf_bank,
  output logic                 bank_swap,
  output logic [3:0]           resume_kind
);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_CHECK, S_DRAIN} st_t;

  st_t              st;
  logic [CW-1:0]    cnt;
  logic [PRIO_W-1:0] thr_q;
  logic [1:0]       fpriv_q;
  logic [3:0]       kind_q;

  logic             found;
  logic [PRIO_W-1:0] best;
  logic [IW-1:0]    win;
  logic [PRIO_W-1:0] cmp_prio;
  logic             preempt;
  logic [CW-1:0]    seen;

  always_comb begin
    found = 1'b0;
    best  = '0;
    win   = '0;
    for (int i = 0; i < NREQ; i++) begin
      if (req_valid[i] && (!found || req_prio[i*PRIO_W +: PRIO_W] > best)) begin
        found = 1'b1;
        best  = req_prio[i*PRIO_W +: PRIO_W];
        win   = IW'(i);
      end
    end
  end

  assign cmp_prio   = (st == S_IDLE) ? thread_prio : thr_q;
  assign preempt    = found && (best > cmp_prio);
  assign busy       = (st != S_IDLE);
  assign rf_wr_en   = (st == S_FETCH) && rsp_valid && !preempt;
  assign rf_wr_line = cnt;
  assign rf_wr_data = rsp_data;
  assign seen       = cnt + CW'(rsp_valid);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      cnt         <= '0;
      thr_q       <= '0;
      fpriv_q     <= '0;
      kind_q      <= '0;
      fetch_req   <= 1'b0;
      done        <= 1'b0;
      redirect    <= 1'b0;
      tgt_thread  <= 1'b0;
      tgt_idx     <= '0;
      tgt_priv    <= '0;
      rf_bank     <= '0;
      bank_swap   <= 1'b0;
      resume_kind <= '0;
    end else begin
      fetch_req <= 1'b0;
      done      <= 1'b0;
      redirect  <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          thr_q   <= thread_prio;
          fpriv_q <= frame_priv;
          kind_q  <= frame_kind;
          cnt     <= '0;
          if (preempt) begin
            redirect   <= 1'b1;
            tgt_thread <= 1'b0;
            tgt_idx    <= win;
            tgt_priv   <= req_priv[win*2 +: 2];
            rf_bank    <= cur_priv;
            bank_swap  <= 1'b0;
          end else begin
            fetch_req <= 1'b1;
            st        <= S_FETCH;
          end
        end
        S_FETCH: begin
          if (preempt) begin
            redirect   <= 1'b1;
            tgt_thread <= 1'b0;
            tgt_idx    <= win;
            tgt_priv   <= req_priv[win*2 +: 2];
            rf_bank    <= cur_priv;
            bank_swap  <= 1'b0;
            cnt        <= seen;
            st         <= (seen == CW'(LINES)) ? S_IDLE : S_DRAIN;
          end else if (rsp_valid) begin
            cnt <= seen;
            if (seen == CW'(LINES)) st <= S_CHECK;
          end
        end
        S_CHECK: begin
          st <= S_IDLE;
          if (preempt) begin
            redirect   <= 1'b1;
            tgt_thread <= 1'b0;
            tgt_idx    <= win;
            tgt_priv   <= req_priv[win*2 +: 2];
            rf_bank    <= cur_priv;
            bank_swap  <= 1'b0;
          end else begin
            done        <= 1'b1;
            tgt_thread  <= 1'b1;
            tgt_priv    <= fpriv_q;
            rf_bank     <= fpriv_q;
            bank_swap   <= (fpriv_q != cur_priv);
            resume_kind <= kind_q;
          end
        end
        default: if (rsp_valid) begin
          cnt <= seen;
          if (seen == CW'(LINES)) st <= S_IDLE;
        end
      endcase
    end
  end

  p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && redirect));
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_thread_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (tgt_thread && !busy));
  p_fetch_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> busy);
  p_line_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr_en |-> (rf_wr_line < CW'(LINES)));
  p_drain_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DRAIN) |-> (!rf_wr_en && !done));
  p_redirect_bank_r8: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> (!bank_swap && !tgt_thread));
  p_busy_nostart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> !fetch_req);

endmodule

// File: tb/tb_sup_return_arb.sv
module tb_sup_return_arb;
  localparam int NREQ = 4, PW = 3, DW = 16, LINES = 5;
  localparam int IW = 2, CW = 3;

  logic clk = 0, rst_n = 0, start = 0;
  logic [PW-1:0] thread_prio = 0;
  logic [1:0] frame_priv = 0, cur_priv = 0;
  logic [3:0] frame_kind = 0;
  logic [NREQ-1:0] req_valid = 0;
  logic [NREQ*PW-1:0] req_prio = 0;
  logic [NREQ*2-1:0] req_priv = 0;
  logic rsp_valid = 0;
  logic [DW-1:0] rsp_data = 0;
  logic busy, fetch_req, rf_wr_en, done, redirect, tgt_thread, bank_swap;
  logic [CW-1:0] rf_wr_line;
  logic [DW-1:0] rf_wr_data;
  logic [IW-1:0] tgt_idx;
  logic [1:0] tgt_priv, rf_bank;
  logic [3:0] resume_kind;

  int checks = 0, failures = 0, cyc = 0;

  sup_return_arb #(.NREQ(NREQ), .PRIO_W(PW), .DATA_W(DW), .LINES(LINES)) dut (
    .clk, .rst_n, .start, .thread_prio, .frame_priv, .frame_kind, .cur_priv,
    .req_valid, .req_prio, .req_priv, .rsp_valid, .rsp_data, .busy, .fetch_req,
    .rf_wr_en, .rf_wr_line, .rf_wr_data, .done, .redirect, .tgt_thread,
    .tgt_idx, .tgt_priv, .rf_bank, .bank_swap, .resume_kind);

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      failures++;
      $display("FAIL watchdog act=%0d exp=<200000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic feed_lines(input int first, input int last, input int tag);
    for (int l = first; l <= last; l++) begin
      rsp_valid = 1; rsp_data = DW'(tag * 8 + l);
      #1;
      chk(rf_wr_en == 1 && rf_wr_line == CW'(l), "R4 line", int'(rf_wr_line), l);
      chk(rf_wr_data == DW'(tag * 8 + l), "R4 data", int'(rf_wr_data), tag * 8 + l);
      step();
    end
    rsp_valid = 0;
  endtask

  task automatic run_case(input int v, input int s, input int t, input int tag);
    int w, b, exp_pre;
    int fp, cp, kind;
    bit f;
    fp = (tag + s) % 4; cp = (tag / 3) % 4; kind = 1 + tag % 3;
    req_valid = NREQ'(v);
    for (int i = 0; i < NREQ; i++) begin
      req_prio[i*PW +: PW] = PW'((s * 3 + i * 5 + s * i) % 8);
      req_priv[i*2 +: 2] = 2'((i + s) % 4);
    end
    thread_prio = PW'(t); frame_priv = 2'(fp); cur_priv = 2'(cp); frame_kind = 4'(kind);
    f = 0; b = 0; w = 0;
    for (int i = 0; i < NREQ; i++)
      if (v[i] && (!f || (s * 3 + i * 5 + s * i) % 8 > b)) begin
        f = 1; b = (s * 3 + i * 5 + s * i) % 8; w = i;
      end
    exp_pre = (f && b > t) ? 1 : 0;
    start = 1; step(); start = 0;
    if (exp_pre == 1) begin
      chk(redirect == 1 && fetch_req == 0, "R2 redirect", int'(redirect), 1);
      chk(tgt_idx == IW'(w), "R1 winner", int'(tgt_idx), w);
      chk(tgt_priv == 2'((w + s) % 4), "R2 tgt_priv", int'(tgt_priv), (w + s) % 4);
      chk(rf_bank == 2'(cp) && bank_swap == 0, "R8 redirect bank", int'(rf_bank), cp);
      chk(busy == 0, "R2 idle", int'(busy), 0);
    end else begin
      chk(fetch_req == 1 && redirect == 0, "R1 R3 fetch", int'(fetch_req), 1);
      chk(busy == 1, "R3 busy", int'(busy), 1);
      feed_lines(0, LINES - 1, tag);
      chk(done == 0 && busy == 1, "R5 check cycle", int'(done), 0);
      step();
      chk(done == 1 && redirect == 0 && tgt_thread == 1, "R5 done", int'(done), 1);
      chk(resume_kind == 4'(kind), "R5 kind", int'(resume_kind), kind);
      chk(rf_bank == 2'(fp) && tgt_priv == 2'(fp), "R8 resume bank", int'(rf_bank), fp);
      chk(bank_swap == (fp != cp), "R8 swap", int'(bank_swap), int'(fp != cp));
      step();
      chk(done == 0, "R5 pulse", int'(done), 0);
    end
  endtask

  task automatic begin_fetch();
    req_valid = 4'b0001; req_prio = '0; req_prio[0 +: PW] = 3'd2;
    req_priv = 8'b11_10_01_00;
    thread_prio = 3'd3; cur_priv = 2'd1; frame_priv = 2'd2; frame_kind = 4'd2;
    start = 1; step(); start = 0;
    chk(fetch_req == 1, "R3 fetch", int'(fetch_req), 1);
  endtask

  task automatic abandon_case(input int k, input int wr);
    int rem;
    begin_fetch();
    if (k > 0) feed_lines(0, k - 1, 20 + k);
    req_valid = 4'b0111; req_prio[1*PW +: PW] = 3'd5; req_prio[2*PW +: PW] = 3'd5;
    rsp_valid = wr[0]; rsp_data = 16'hDEAD;
    #1;
    chk(rf_wr_en == 0, "R6 suppress", int'(rf_wr_en), 0);
    step();
    rsp_valid = 0; req_valid = 4'b0001;
    chk(redirect == 1 && done == 0, "R6 redirect", int'(redirect), 1);
    chk(tgt_idx == 2'd1 && tgt_priv == 2'd1, "R1 R6 tie low index", int'(tgt_idx), 1);
    chk(rf_bank == 2'd1 && bank_swap == 0, "R8 abandon bank", int'(rf_bank), 1);
    rem = LINES - k - wr;
    chk(busy == (rem > 0), "R6 drain busy", int'(busy), int'(rem > 0));
    for (int j = 0; j < rem; j++) begin
      rsp_valid = 1; rsp_data = 16'hBEEF;
      start = (j == 0);
      #1;
      chk(rf_wr_en == 0, "R6 ignored line", int'(rf_wr_en), 0);
      step();
      start = 0;
      chk(fetch_req == 0 && done == 0 && redirect == 0, "R9 start ignored", int'(fetch_req), 0);
    end
    rsp_valid = 0;
    chk(busy == 0, "R6 drained", int'(busy), 0);
    step();
    chk(fetch_req == 0 && done == 0, "R9 no late effect", int'(fetch_req), 0);
  endtask

  initial begin
    step(); step();
    chk(busy == 0 && done == 0 && redirect == 0 && fetch_req == 0 && rf_wr_en == 0,
        "R10 reset", int'(busy), 0);
    rst_n = 1; step();
    for (int s = 0; s < 4; s++)
      for (int v = 0; v < 16; v++)
        for (int t = 0; t < 8; t++)
          run_case(v, s, t, s * 128 + v * 8 + t);
    for (int k = 0; k < LINES; k++)
      for (int wr = 0; wr < 2; wr++)
        abandon_case(k, wr);
    begin_fetch();
    feed_lines(0, LINES - 1, 30);
    req_valid = 4'b1001; req_prio[3*PW +: PW] = 3'd7;
    step();
    chk(redirect == 1 && done == 0, "R7 late redirect", int'(redirect), 1);
    chk(tgt_idx == 2'd3 && tgt_priv == 2'd3, "R7 late target", int'(tgt_idx), 3);
    chk(busy == 0, "R7 idle", int'(busy), 0);
    req_valid = 0; step();
    begin_fetch();
    feed_lines(0, 1, 31);
    req_valid = 4'b0011; req_prio[1*PW +: PW] = 3'd3;
    step();
    chk(redirect == 0 && busy == 1, "R1 equal prio no preempt", int'(redirect), 0);
    feed_lines(2, LINES - 1, 31);
    step();
    chk(done == 1 && bank_swap == 1 && rf_bank == 2'd2, "R5 R8 swap resume", int'(rf_bank), 2);
    step();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule